// File: doc/BRIEF.md
# Manual Front-Panel Memory Loader

This block lets an operator fill and inspect an 8-bit memory using only switches and push buttons. It keeps its own loader address register. A single phase bit chooses between an address phase and a data phase. In the address phase the block drives the register value onto the system data bus and raises the memory-address-register write strobe. In the data phase it drives the data switch value and raises the RAM write strobe. Each press of the step button produces one system clock pulse. That pulse is ORed outside the block with the normal clock, so the selected external register captures the bus.

A mode switch picks the operating mode. In write mode each step press alternates between loading the address and writing the data. In read mode every press reloads the address, so the stored byte can be viewed on the memory's own display. With auto-increment on, the address register advances at the end of each data write in write mode, and at the end of every step in read mode. A set-address press copies the data switches straight into the address register at any time. A reset press clears the register and sends a system-wide reset pulse. All buttons and switches pass through a synchronizer and a debounce filter first.

Top module: `front_panel_loader`

## Requirements
- R1: With the active switch off, `ctl_store_off`, `bus_oe`, `mar_we` and `ram_we` are all 0 and `bus_val` is 0.
- R2: With the active switch on, `ctl_store_off` and `bus_oe` are both 1.
- R3: In the address phase (active), `mar_we` = 1, `ram_we` = 0 and `bus_val` equals the loader address register.
- R4: In the data phase (active), `ram_we` = 1, `mar_we` = 0 and `bus_val` equals the data switches.
- R5: In write mode (`sw_write_mode` = 1), each accepted step press toggles the phase between address and data.
- R6: In read mode (`sw_write_mode` = 0), the phase is held at address, and switching into read mode from the data phase returns it to address.
- R7: With `sw_auto_inc` = 1, the address register adds one on every step in read mode. In write mode it adds one only on the step that leaves the data phase. With `sw_auto_inc` = 0 it never changes on a step.
- R8: A set-address press loads the data switches into the address register in either phase and mode, with no step press needed, and leaves the phase unchanged.
- R9: Incrementing wraps from 255 to 0, and the carry passes from the low nibble to the high nibble (0x0F becomes 0x10).
- R10: Each step press made while active gives exactly one `step_clk` pulse, one cycle wide. A press made while inactive gives no pulse and changes neither the phase nor the address.
- R11: A reset press clears the address register to 0, returns the phase to address and emits one `sys_reset` pulse of RST_LEN cycles (4 by default).
- R12: A button or switch level that lasts fewer than DEB_CYCLES (8 by default) clock cycles after synchronization has no effect.
- R13: `mar_we` and `ram_we` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for filters and state |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sw_active | input | 1 | Loader enable switch |
| sw_data | input | W | Data switches (8 by default) |
| btn_step | input | 1 | Single-step clock button |
| btn_set_addr | input | 1 | Load data switches into address register |
| sw_auto_inc | input | 1 | Auto-increment enable switch |
| sw_write_mode | input | 1 | 1 = write mode, 0 = read mode |
| btn_reset | input | 1 | System reset button |
| ctl_store_off | output | 1 | Disables the microcode control store outputs |
| mar_we | output | 1 | Memory address register write strobe |
| ram_we | output | 1 | RAM write strobe |
| bus_oe | output | 1 | Enable for driving the data bus |
| bus_val | output | W | Value offered to the data bus |
| step_clk | output | 1 | One-cycle loader clock pulse per step |
| sys_reset | output | 1 | System-wide reset pulse |

## Verification
The hardest case to reach is a set-address press made while the block sits in the data phase. In that phase the bus shows the switches rather than the address, so the load cannot be seen directly. The stimulus first steps into the data phase, then loads a new address, and then steps once more with auto-increment on. The address that appears on the bus is the loaded value plus one, and that result shows the load took place and the phase did not move. A similar indirect route checks the forced return to the address phase: the stimulus changes the mode switch while in the data phase, with no step press.

// File: rtl/loader_pkg.sv
package loader_pkg;
   typedef enum logic {
      PH_ADDR = 1'b0,
      PH_DATA = 1'b1
   } phase_e;

   localparam int NIB_W = 4;
endpackage

// File: rtl/deb_filter.sv
module deb_filter #(
   parameter int N          = 1,
   parameter int DEB_CYCLES = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] clean
);
   localparam int CW = $clog2(DEB_CYCLES + 1);

   for (genvar i = 0; i < N; i++) begin : g_ch
      logic          s1, s2;
      logic [CW-1:0] cnt;
      logic          lvl;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            cnt <= '0;
            lvl <= 1'b0;
         end else begin
            s1 <= raw[i];
            s2 <= s1;
            if (s2 == lvl) begin
               cnt <= '0;
            end else if (cnt == CW'(DEB_CYCLES - 1)) begin
               cnt <= '0;
               lvl <= s2;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end

      assign clean[i] = lvl;
   end
endmodule

// File: rtl/loader_addr.sv
module loader_addr
   import loader_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam int NN = W / NIB_W;

   logic [NN:0] carry;
   assign carry[0] = inc;

   for (genvar i = 0; i < NN; i++) begin : g_nib
      logic [NIB_W-1:0] nib_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          nib_q <= '0;
         else if (clr)        nib_q <= '0;
         else if (load)       nib_q <= din[i*NIB_W +: NIB_W];
         else if (carry[i])   nib_q <= nib_q + 1'b1;
      end

      assign carry[i+1]         = carry[i] & (&nib_q);
      assign q[i*NIB_W +: NIB_W] = nib_q;
   end
endmodule

// File: rtl/loader_phase.sv
module loader_phase
   import loader_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clear,
   input  logic   write_mode,
   input  logic   advance,
   output phase_e phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  phase <= PH_ADDR;
      else if (clear || !write_mode) phase <= PH_ADDR;
      else if (advance)            phase <= (phase == PH_ADDR) ? PH_DATA : PH_ADDR;
   end
endmodule

// File: rtl/front_panel_loader.sv
module front_panel_loader
   import loader_pkg::*;
#(
   parameter int W          = 8,
   parameter int DEB_CYCLES = 8,
   parameter int RST_LEN    = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sw_active,
   input  logic [W-1:0] sw_data,
   input  logic         btn_step,
   input  logic         btn_set_addr,
   input  logic         sw_auto_inc,
   input  logic         sw_write_mode,
   input  logic         btn_reset,
   output logic         ctl_store_off,
   output logic         mar_we,
   output logic         ram_we,
   output logic         bus_oe,
   output logic [W-1:0] bus_val,
   output logic         step_clk,
   output logic         sys_reset
);
   localparam int NCH  = W + 6;
   localparam int I_RST = 0;
   localparam int I_SET = 1;
   localparam int I_STP = 2;
   localparam int I_WM  = 3;
   localparam int I_INC = 4;
   localparam int I_ACT = 5;
   localparam int RCW  = $clog2(RST_LEN + 1);

   if (W % NIB_W != 0) begin : g_bad_width
      $error("W must be a multiple of the nibble width");
   end
   if (DEB_CYCLES < 2) begin : g_bad_deb
      $error("DEB_CYCLES must be at least 2");
   end
   if (RST_LEN < 1) begin : g_bad_rst
      $error("RST_LEN must be at least 1");
   end

   logic [NCH-1:0] raw, clean;
   assign raw = {sw_data, sw_active, sw_auto_inc, sw_write_mode,
                 btn_step, btn_set_addr, btn_reset};

   deb_filter #(.N(NCH), .DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw),
      .clean (clean)
   );

   logic [W-1:0] data_db;
   logic         act, wmode, auto_inc;
   assign data_db  = clean[NCH-1:6];
   assign act      = clean[I_ACT];
   assign wmode    = clean[I_WM];
   assign auto_inc = clean[I_INC];

   logic [2:0] btn_prev, press;
   logic       rst_p, set_p, step_p;
   assign press  = clean[I_STP:I_RST] & ~btn_prev;
   assign rst_p  = press[I_RST];
   assign set_p  = press[I_SET];
   assign step_p = press[I_STP];

   logic           commit;
   logic [RCW-1:0] rst_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         btn_prev <= '0;
         commit   <= 1'b0;
         rst_cnt  <= '0;
      end else begin
         btn_prev <= clean[I_STP:I_RST];
         commit   <= step_p & act;
         if (rst_p)              rst_cnt <= RCW'(RST_LEN);
         else if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
      end
   end

   phase_e phase_q;
   loader_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (rst_p),
      .write_mode (wmode),
      .advance    (commit),
      .phase      (phase_q)
   );

   logic         inc_en;
   logic [W-1:0] addr_q;
   assign inc_en = commit & auto_inc & (!wmode || phase_q == PH_DATA);

   loader_addr #(.W(W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rst_p),
      .load  (set_p),
      .din   (data_db),
      .inc   (inc_en),
      .q     (addr_q)
   );

   assign step_clk      = commit;
   assign sys_reset     = (rst_cnt != '0);
   assign ctl_store_off = act;
   assign bus_oe        = act;
   assign mar_we        = act & (phase_q == PH_ADDR);
   assign ram_we        = act & (phase_q == PH_DATA);
   assign bus_val       = !act ? '0 : (phase_q == PH_DATA) ? data_db : addr_q;
endmodule

// File: rtl/loader_checks.sv
module loader_checks #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ctl_store_off,
   input logic         mar_we,
   input logic         ram_we,
   input logic         bus_oe,
   input logic         step_clk,
   input logic         sys_reset,
   input logic         wmode,
   input logic         phase,
   input logic         set_p,
   input logic         rst_p,
   input logic [W-1:0] addr
);
   assert_strobes_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(mar_we && ram_we));

   assert_inactive_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_store_off |-> (!mar_we && !ram_we && !bus_oe));

   assert_step_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      step_clk |=> !step_clk);

   assert_read_forces_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wmode |=> !phase);

   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_clk && !set_p && !rst_p) |=> $stable(addr));

   assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_p |=> (addr == '0 && !phase && sys_reset));
endmodule

bind front_panel_loader loader_checks #(.W(W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_store_off (ctl_store_off),
   .mar_we        (mar_we),
   .ram_we        (ram_we),
   .bus_oe        (bus_oe),
   .step_clk      (step_clk),
   .sys_reset     (sys_reset),
   .wmode         (wmode),
   .phase         (phase_q),
   .set_p         (set_p),
   .rst_p         (rst_p),
   .addr          (addr_q)
);

// File: tb/tb_front_panel_loader.sv
module tb_front_panel_loader;
   localparam int W    = 8;
   localparam int HOLD = 40;
   localparam int RLEN = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_active = 1'b0, btn_step = 1'b0, btn_set_addr = 1'b0;
   logic sw_auto_inc = 1'b0, sw_write_mode = 1'b0, btn_reset = 1'b0;
   logic [W-1:0] sw_data = '0;
   logic ctl_store_off, mar_we, ram_we, bus_oe, step_clk, sys_reset;
   logic [W-1:0] bus_val;

   always #2 clk = ~clk;

   front_panel_loader #(.W(W), .DEB_CYCLES(8), .RST_LEN(RLEN)) dut (
      .clk(clk), .rst_n(rst_n), .sw_active(sw_active), .sw_data(sw_data),
      .btn_step(btn_step), .btn_set_addr(btn_set_addr), .sw_auto_inc(sw_auto_inc),
      .sw_write_mode(sw_write_mode), .btn_reset(btn_reset),
      .ctl_store_off(ctl_store_off), .mar_we(mar_we), .ram_we(ram_we),
      .bus_oe(bus_oe), .bus_val(bus_val), .step_clk(step_clk), .sys_reset(sys_reset)
   );

   typedef struct {
      string       tag;
      logic        dis, oe, mar, ram;
      logic [W-1:0] bus;
      int          pulses, resets;
   } exp_t;

   exp_t q[$];
   event ev_chk;
   int   n_tests = 0, n_fail = 0;

   // model
   logic        m_act = 0, m_inc = 0, m_wm = 0, m_phase = 0;
   logic [W-1:0] m_addr = 0, m_data = 0;
   int          m_pulses = 0, m_resets = 0;

   // output monitors, sampled on falling edge
   int  seen_pulses = 0, seen_hi = 0, seen_resets = 0, rst_width = 0, last_rst_width = 0;
   logic prev_step = 0, prev_rst = 0;
   always @(negedge clk) begin
      if (step_clk) seen_hi++;
      if (step_clk && !prev_step) seen_pulses++;
      if (sys_reset) rst_width++;
      if (sys_reset && !prev_rst) seen_resets++;
      if (!sys_reset && prev_rst) begin last_rst_width = rst_width; rst_width = 0; end
      prev_step = step_clk;
      prev_rst  = sys_reset;
   end

   task automatic push_exp(input string tag);
      exp_t e;
      e.tag = tag;
      e.dis = m_act; e.oe = m_act;
      e.mar = m_act & !m_phase; e.ram = m_act & m_phase;
      e.bus = !m_act ? '0 : (m_phase ? m_data : m_addr);
      e.pulses = m_pulses; e.resets = m_resets;
      q.push_back(e);
      ->ev_chk;
      repeat (3) @(posedge clk);
   endtask

   task automatic fail1(input string tag, input string f, input int act, input int exp);
      $display("FAIL %s %s: actual %0h expected %0h", tag, f, act, exp);
   endtask

   initial begin : monitor
      forever begin
         @(ev_chk);
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            bad = 0;
            n_tests++;
            if (ctl_store_off !== e.dis) begin bad = 1; fail1(e.tag, "ctl_store_off", ctl_store_off, e.dis); end
            if (bus_oe !== e.oe)         begin bad = 1; fail1(e.tag, "bus_oe", bus_oe, e.oe); end
            if (mar_we !== e.mar)        begin bad = 1; fail1(e.tag, "mar_we", mar_we, e.mar); end
            if (ram_we !== e.ram)        begin bad = 1; fail1(e.tag, "ram_we", ram_we, e.ram); end
            if (bus_val !== e.bus)       begin bad = 1; fail1(e.tag, "bus_val", bus_val, e.bus); end
            if (seen_pulses != e.pulses) begin bad = 1; fail1(e.tag, "step pulses", seen_pulses, e.pulses); end
            if (seen_resets != e.resets) begin bad = 1; fail1(e.tag, "reset pulses", seen_resets, e.resets); end
            if (bad) n_fail++;
         end
      end
   end

   task automatic set_sw(input logic act, input logic [W-1:0] d, input logic inc, input logic wm);
      sw_active = act; sw_data = d; sw_auto_inc = inc; sw_write_mode = wm;
      m_act = act; m_data = d; m_inc = inc; m_wm = wm;
      if (!wm) m_phase = 0;
      repeat (HOLD) @(posedge clk);
   endtask

   task automatic press_step();
      btn_step = 1; repeat (HOLD) @(posedge clk);
      btn_step = 0; repeat (HOLD) @(posedge clk);
      if (m_act) begin
         m_pulses++;
         if (!m_wm) begin
            m_phase = 0;
            if (m_inc) m_addr = m_addr + 1'b1;
         end else if (!m_phase) begin
            m_phase = 1;
         end else begin
            m_phase = 0;
            if (m_inc) m_addr = m_addr + 1'b1;
         end
      end
   endtask

   task automatic press_set();
      btn_set_addr = 1; repeat (HOLD) @(posedge clk);
      btn_set_addr = 0; repeat (HOLD) @(posedge clk);
      m_addr = m_data;
   endtask

   task automatic press_reset();
      btn_reset = 1; repeat (HOLD) @(posedge clk);
      btn_reset = 0; repeat (HOLD) @(posedge clk);
      m_addr = 0; m_phase = 0; m_resets++;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : driver
      repeat (5) @(posedge clk);
      rst_n = 1;
      repeat (HOLD) @(posedge clk);
      push_exp("R1 reset state inactive");

      set_sw(1, 8'h3C, 1, 1);
      push_exp("R2 R3 active address phase after reset");
      press_set();
      push_exp("R8 set address in address phase");
      set_sw(1, 8'hA5, 1, 1);
      press_step();
      push_exp("R4 R5 R10 step into data phase");
      press_step();
      push_exp("R5 R7 leave data phase increments");

      set_sw(1, 8'h11, 0, 1);
      press_step();
      push_exp("R5 data phase with inc off");
      press_step();
      push_exp("R7 inc off no change");

      set_sw(1, 8'h11, 1, 0);
      press_step();
      push_exp("R6 R7 read mode step increments");
      press_step();
      push_exp("R6 R7 read mode second step");

      set_sw(1, 8'h22, 1, 1);
      press_step();
      push_exp("R5 write mode into data phase");
      set_sw(1, 8'h22, 1, 0);
      push_exp("R6 mode change forces address phase");

      set_sw(1, 8'h0F, 1, 0);
      press_set();
      press_step();
      push_exp("R9 nibble carry 0F to 10");
      set_sw(1, 8'hFF, 1, 0);
      press_set();
      press_step();
      push_exp("R9 wrap FF to 00");

      set_sw(1, 8'h30, 1, 1);
      press_step();
      push_exp("R4 data phase before hidden set");
      set_sw(1, 8'h55, 1, 1);
      press_set();
      push_exp("R8 set during data phase keeps phase");
      press_step();
      push_exp("R8 R7 loaded value plus one");

      // glitch shorter than debounce window
      btn_step = 1; repeat (3) @(posedge clk);
      btn_step = 0; repeat (HOLD) @(posedge clk);
      push_exp("R12 short glitch ignored");

      set_sw(0, 8'h55, 1, 1);
      push_exp("R1 inactive outputs quiet");
      press_step();
      push_exp("R10 inactive press no pulse");
      set_sw(1, 8'h55, 1, 1);
      push_exp("R10 state unchanged after inactive press");

      press_step();
      push_exp("R5 before reset into data phase");
      press_reset();
      push_exp("R11 reset button clears address and phase");

      n_tests++;
      if (last_rst_width != RLEN) begin
         n_fail++;
         $display("FAIL R11 reset pulse width: actual %0d expected %0d", last_rst_width, RLEN);
      end
      n_tests++;
      if (seen_hi != m_pulses) begin
         n_fail++;
         $display("FAIL R10 step high cycles: actual %0d expected %0d", seen_hi, m_pulses);
      end

      repeat (5) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule